// File: doc/BRIEF.md
# Associative Track-Pattern Bank with Missing-Layer Tolerance

The block holds a bank of track patterns. Each pattern keeps one coarse hit address for every detector layer. The default bank has four groups of 128 patterns and six layers, and each address is 12 bits wide. During an event, every layer delivers hit words on its own bus. Each pattern compares every valid hit against the address it stores for that layer. When a hit matches, the pattern sets a per-layer flag, and that flag stays set until the next event opens. A separate write port loads the stored addresses, one layer of one pattern per clock.

When the event is closed, each pattern counts the layers it missed. It does this with a three-bit thermometer code that passes through one stage per layer. The code starts at 111. A matched layer leaves it unchanged, and a missed layer shifts it right by one. Once the code reaches 000 it stays there. A two-bit tolerance input picks which bit of the final code qualifies the pattern as a road. All road flags are loaded into an output vector on the closing clock edge.

A small controller sequences the event and has three states:
- `PAM_IDLE` is the state after reset.
- `PAM_COLLECT` means an event is open and hits are being accepted.
- `PAM_CLOSED` means the road vector holds the result of the last event.

It has these transitions:
- `ev_start` moves the controller from any state to `PAM_COLLECT` and clears every layer flag on that edge.
- `ev_end` without `ev_start` moves it from `PAM_COLLECT` to `PAM_CLOSED` and captures the roads.
- In all other cases the controller stays in its current state.

Top module: `pam_bank`

## Requirements
- R1: While `rst_n` is low, the road vector is all zeros and the controller is in `PAM_IDLE`. Every stored address and every layer flag is zero.
- R2: On a clock edge with `ld_we` high, pattern `ld_pat` layer `ld_layer` stores `ld_addr`. Every later comparison uses the new value.
- R3: A clock edge with `ev_start` high clears all layer flags of all patterns and opens an event. Hits presented in that same cycle are not latched.
- R4: Hits are latched only while an event is open. In that case, a hit on layer L with `hit_vld[L]` high and `hit_addr[L*ADDR_W +: ADDR_W]` equal to a pattern's stored layer-L address sets that pattern's layer-L flag. The flag stays set until the next `ev_start`, whatever hits follow.
- R5: The missing-layer code starts at 111. It goes through the layers in index order. A matched layer keeps the code, and a missed layer shifts it right one place with a 0 entering at the top. The result is 111 for no miss, 011 for one miss, 001 for two misses and 000 for three or more.
- R6: `tol` = 0 takes code bit 2 as the road flag, `tol` = 1 takes bit 1, and `tol` = 2 or 3 takes bit 0. So a pattern is a road when its missed layers are at most min(`tol`, 2).
- R7: A clock edge with `ev_end` high, `ev_start` low and an event open does three things. It loads the road flags into `road`, where bit i belongs to pattern i = group × `PATS_PER_BLK` + position. It uses the `tol` value of that cycle. It closes the event.
- R8: `ev_end` has no effect when no event is open. `road` changes only on a capture edge as in R7.
- R9: When `ev_start` and `ev_end` are both high on the same edge, the start wins. No capture takes place, and the event is reopened with cleared flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_we | input | 1 | Pattern write enable |
| ld_pat | input | PAT_W | Index of the pattern to write |
| ld_layer | input | LYR_W | Layer of the pattern to write |
| ld_addr | input | ADDR_W | Address value to store |
| ev_start | input | 1 | Opens an event and clears the layer flags |
| ev_end | input | 1 | Closes the event and captures the roads |
| hit_vld | input | LAYERS | Per-layer hit valid |
| hit_addr | input | LAYERS*ADDR_W | Per-layer hit address, layer L in slice L*ADDR_W |
| tol | input | 2 | Missing-layer tolerance selector |
| road | output | NPAT | Registered road flag per pattern |

## Verification
The assertions check every cycle for the following:
- Layer flags are cleared after a start.
- A flag never falls while an event stays open.
- No flag moves when no event is open.
- The road vector holds except on a capture edge.
- The controller lands in the right state after a start or a close.

Only the bench's scenarios can show that the captured flags carry the right values. That covers the thermometer code over every subset of missed layers under each tolerance, the mapping of patterns to road bits, hits spread over several cycles, and rewritten addresses.

// File: rtl/pam_pkg.sv
package pam_pkg;

    typedef enum logic [1:0] {
        PAM_IDLE    = 2'd0,
        PAM_COLLECT = 2'd1,
        PAM_CLOSED  = 2'd2
    } pam_state_e;

    // one stage of the missing-layer thermometer
    function automatic logic [2:0] maj_step(input logic [2:0] code_in, input logic matched);
        maj_step = matched ? code_in : {1'b0, code_in[2:1]};
    endfunction

    // pick the road qualifier bit for a tolerance setting
    function automatic logic road_pick(input logic [2:0] code, input logic [1:0] tol);
        case (tol)
            2'd0:    road_pick = code[2];
            2'd1:    road_pick = code[1];
            default: road_pick = code[0];
        endcase
    endfunction

endpackage

// File: rtl/pam_ctrl.sv
module pam_ctrl
    import pam_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_start,
    input  logic       ev_end,
    output pam_state_e state,
    output logic       clr,
    output logic       acc,
    output logic       cap
);

    pam_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PAM_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PAM_IDLE: begin
                if (ev_start) state_d = PAM_COLLECT;
            end
            PAM_COLLECT: begin
                if (ev_start)    state_d = PAM_COLLECT;
                else if (ev_end) state_d = PAM_CLOSED;
            end
            PAM_CLOSED: begin
                if (ev_start) state_d = PAM_COLLECT;
            end
            default: state_d = PAM_IDLE;
        endcase
    end

    always_comb begin
        clr = 1'b0;
        acc = 1'b0;
        cap = 1'b0;
        unique case (state_q)
            PAM_IDLE:    clr = ev_start;
            PAM_COLLECT: begin
                clr = ev_start;
                acc = !ev_start;
                cap = ev_end && !ev_start;
            end
            PAM_CLOSED:  clr = ev_start;
            default:     clr = 1'b0;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/pam_majority.sv
module pam_majority
    import pam_pkg::*;
#(
    parameter int LAYERS = 6
) (
    input  logic [LAYERS-1:0] seen,
    output logic [2:0]        code
);

    logic [LAYERS:0][2:0] chain;

    assign chain[0] = 3'b111;

    for (genvar l = 0; l < LAYERS; l++) begin : g_stage
        assign chain[l+1] = maj_step(chain[l], seen[l]);
    end

    assign code = chain[LAYERS];

endmodule

// File: rtl/pam_pattern.sv
module pam_pattern #(
    parameter int LAYERS = 6,
    parameter int ADDR_W = 12,
    parameter int LYR_W  = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [LYR_W-1:0]         wr_layer,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [LAYERS-1:0]        hit_vld,
    input  logic [LAYERS*ADDR_W-1:0] hit_addr,
    input  logic                     clr,
    input  logic                     acc,
    output logic [LAYERS-1:0]        seen
);

    for (genvar l = 0; l < LAYERS; l++) begin : g_lyr
        logic [ADDR_W-1:0] stored_q;
        logic              hit_now;
        logic              seen_q;

        always_ff @(posedge clk) begin
            if (!rst_n)                                  stored_q <= '0;
            else if (wr_en && wr_layer == LYR_W'(l))     stored_q <= wr_addr;
        end

        assign hit_now = hit_vld[l] && (hit_addr[l*ADDR_W +: ADDR_W] == stored_q);

        always_ff @(posedge clk) begin
            if (!rst_n)              seen_q <= 1'b0;
            else if (clr)            seen_q <= 1'b0;
            else if (acc && hit_now) seen_q <= 1'b1;
        end

        assign seen[l] = seen_q;
    end

endmodule

// File: rtl/pam_bank.sv
module pam_bank
    import pam_pkg::*;
#(
    parameter int NBLK         = 4,
    parameter int PATS_PER_BLK = 128,
    parameter int LAYERS       = 6,
    parameter int ADDR_W       = 12,
    localparam int NPAT  = NBLK * PATS_PER_BLK,
    localparam int PAT_W = (NPAT > 1) ? $clog2(NPAT) : 1,
    localparam int LYR_W = (LAYERS > 1) ? $clog2(LAYERS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ld_we,
    input  logic [PAT_W-1:0]         ld_pat,
    input  logic [LYR_W-1:0]         ld_layer,
    input  logic [ADDR_W-1:0]        ld_addr,
    input  logic                     ev_start,
    input  logic                     ev_end,
    input  logic [LAYERS-1:0]        hit_vld,
    input  logic [LAYERS*ADDR_W-1:0] hit_addr,
    input  logic [1:0]               tol,
    output logic [NPAT-1:0]          road
);

    pam_state_e               st_q;
    logic                     clr, acc, cap;
    logic [NPAT*LAYERS-1:0]   seen_all;
    logic [NPAT-1:0]          road_d;

    pam_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_start (ev_start),
        .ev_end   (ev_end),
        .state    (st_q),
        .clr      (clr),
        .acc      (acc),
        .cap      (cap)
    );

    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        for (genvar i = 0; i < PATS_PER_BLK; i++) begin : g_pat
            localparam int P = b * PATS_PER_BLK + i;
            logic [LAYERS-1:0] seen;
            logic [2:0]        code;
            logic              sel;

            assign sel = ld_we && (ld_pat == PAT_W'(P));

            pam_pattern #(
                .LAYERS (LAYERS),
                .ADDR_W (ADDR_W),
                .LYR_W  (LYR_W)
            ) u_pat (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en    (sel),
                .wr_layer (ld_layer),
                .wr_addr  (ld_addr),
                .hit_vld  (hit_vld),
                .hit_addr (hit_addr),
                .clr      (clr),
                .acc      (acc),
                .seen     (seen)
            );

            pam_majority #(.LAYERS(LAYERS)) u_maj (
                .seen (seen),
                .code (code)
            );

            assign seen_all[P*LAYERS +: LAYERS] = seen;
            assign road_d[P] = road_pick(code, tol);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)   road <= '0;
        else if (cap) road <= road_d;
    end

endmodule

// File: rtl/pam_bank_chk.sv
module pam_bank_chk
    import pam_pkg::*;
#(
    parameter int NPAT   = 8,
    parameter int LAYERS = 6
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   ev_start,
    input logic                   ev_end,
    input pam_state_e             st,
    input logic [NPAT*LAYERS-1:0] seen,
    input logic [NPAT-1:0]        road
);

    // R3
    clear_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start |=> (seen == '0));

    // R3
    start_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start |=> (st == PAM_COLLECT));

    // R4
    flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PAM_COLLECT && !ev_start) |=> ((seen & $past(seen)) == $past(seen)));

    // R4
    flags_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != PAM_COLLECT && !ev_start) |=> $stable(seen));

    // R7
    close_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PAM_COLLECT && ev_end && !ev_start) |=> (st == PAM_CLOSED));

    // R8
    road_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(st == PAM_COLLECT && ev_end && !ev_start) |=> $stable(road));

endmodule

bind pam_bank pam_bank_chk #(.NPAT(NPAT), .LAYERS(LAYERS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_start (ev_start),
    .ev_end   (ev_end),
    .st       (st_q),
    .seen     (seen_all),
    .road     (road)
);

// File: tb/sim_pam_bank.sv
`timescale 1ns/1ps
module sim_pam_bank;

    localparam int NBLK   = 2;
    localparam int PPB    = 4;
    localparam int LAYERS = 6;
    localparam int ADDR_W = 4;
    localparam int NPAT   = NBLK * PPB;
    localparam int PAT_W  = $clog2(NPAT);
    localparam int LYR_W  = $clog2(LAYERS);

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     ld_we = 1'b0;
    logic [PAT_W-1:0]         ld_pat = '0;
    logic [LYR_W-1:0]         ld_layer = '0;
    logic [ADDR_W-1:0]        ld_addr = '0;
    logic                     ev_start = 1'b0;
    logic                     ev_end = 1'b0;
    logic [LAYERS-1:0]        hit_vld = '0;
    logic [LAYERS*ADDR_W-1:0] hit_addr = '0;
    logic [1:0]               tol = 2'd0;
    logic [NPAT-1:0]          road;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pam_bank #(
        .NBLK         (NBLK),
        .PATS_PER_BLK (PPB),
        .LAYERS       (LAYERS),
        .ADDR_W       (ADDR_W)
    ) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_we    (ld_we),
        .ld_pat   (ld_pat),
        .ld_layer (ld_layer),
        .ld_addr  (ld_addr),
        .ev_start (ev_start),
        .ev_end   (ev_end),
        .hit_vld  (hit_vld),
        .hit_addr (hit_addr),
        .tol      (tol),
        .road     (road)
    );

    function automatic logic [ADDR_W-1:0] addr_of(int p, int l);
        return ADDR_W'((p + l) % 8);
    endfunction

    task automatic check(string req, logic [NPAT-1:0] got, logic [NPAT-1:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: road=%b expected %b", req, got, exp);
        end
    endtask

    task automatic write_one(int p, int l, logic [ADDR_W-1:0] a);
        ld_we = 1'b1; ld_pat = PAT_W'(p); ld_layer = LYR_W'(l); ld_addr = a;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic open_event();
        ev_start = 1'b1;
        @(negedge clk);
        ev_start = 1'b0;
    endtask

    // hits for pattern p on the layers in mask (its own stored addresses)
    task automatic hit_pat(int p, logic [LAYERS-1:0] mask);
        hit_vld = mask;
        for (int l = 0; l < LAYERS; l++) hit_addr[l*ADDR_W +: ADDR_W] = addr_of(p, l);
        @(negedge clk);
        hit_vld = '0;
    endtask

    task automatic hit_noise();
        hit_vld = '1;
        for (int l = 0; l < LAYERS; l++) hit_addr[l*ADDR_W +: ADDR_W] = ADDR_W'(8 + l);
        @(negedge clk);
        hit_vld = '0;
    endtask

    task automatic close_event(logic [1:0] t);
        ev_end = 1'b1; tol = t;
        @(negedge clk);
        ev_end = 1'b0;
    endtask

    function automatic logic expect_road(logic [LAYERS-1:0] mask, int t);
        int miss;
        int lim;
        miss = LAYERS - $countones(mask);
        lim  = (t >= 2) ? 2 : t;
        return miss <= lim;
    endfunction

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [NPAT-1:0] exp;
        logic [NPAT-1:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset", road, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: load every pattern
        for (int p = 0; p < NPAT; p++)
            for (int l = 0; l < LAYERS; l++) write_one(p, l, addr_of(p, l));

        // R5 R6 R7: sweep missed-layer subsets under every tolerance
        for (int t = 0; t < 4; t++) begin
            for (int e = 0; e < 64; e++) begin
                open_event();
                exp = '0;
                for (int p = 0; p < NPAT; p++) begin
                    logic [LAYERS-1:0] m;
                    m = LAYERS'((e + p * 9) % 64);
                    hit_pat(p, m);
                    exp[p] = expect_road(m, t);
                end
                hit_noise();
                close_event(2'(t));
                check("R5/R6/R7 sweep", road, exp);
            end
        end

        // R3: hits in the start cycle are not latched
        hit_vld = '1;
        for (int l = 0; l < LAYERS; l++) hit_addr[l*ADDR_W +: ADDR_W] = addr_of(0, l);
        ev_start = 1'b1;
        @(negedge clk);
        ev_start = 1'b0; hit_vld = '0;
        close_event(2'd3);
        check("R3 start-cycle hits", road, '0);

        // R8: ev_end while closed is ignored
        open_event();
        for (int p = 0; p < NPAT; p++) hit_pat(p, (p % 2 == 0) ? 6'h3f : 6'h3e);
        close_event(2'd0);
        held = 8'b0101_0101;
        check("R7 capture", road, held);
        close_event(2'd2);
        check("R8 end when closed", road, held);

        // R9: start and end together, start wins
        open_event();
        for (int p = 0; p < NPAT; p++) hit_pat(p, '1);
        ev_start = 1'b1; ev_end = 1'b1; tol = 2'd2;
        @(negedge clk);
        ev_start = 1'b0; ev_end = 1'b0;
        check("R9 no capture", road, held);
        close_event(2'd2);
        check("R9 reopened cleared", road, '0);

        // R4: sticky flags across cycles with noise between
        open_event();
        for (int l = 0; l < LAYERS; l++) begin
            hit_pat(2, LAYERS'(1 << l));
            hit_noise();
        end
        close_event(2'd0);
        check("R4 sticky", road, 8'b0000_0100);

        // R2: rewrite pattern 5 layer 2
        write_one(5, 2, 4'd12);
        open_event();
        hit_pat(5, '1);
        close_event(2'd0);
        check("R2 old address misses", road, '0);
        open_event();
        hit_pat(5, 6'b111011);
        hit_vld = 6'b000100;
        hit_addr[2*ADDR_W +: ADDR_W] = 4'd12;
        @(negedge clk);
        hit_vld = '0;
        close_event(2'd0);
        check("R2 new address hits", road, 8'b0010_0000);

        done = 1'b1;
        finish_run();
    end

endmodule